// File: doc/BRIEF.md
# Regulator Start-up and Fault Sequencer

This block is the digital state machine that brings a step-down switching regulator up and takes it down again. When the enable input goes high it first requests the voltage reference and waits a fixed number of timebase ticks for it to settle. It then raises an N-bit soft-start code one step per tick until it reaches full scale. Throughout that ramp it holds the converter in pulse-skipping operation, so that an output that is already charged is not pulled down. Once the ramp is done, normal switching runs.

Frequency control follows the feedback-near-zero flag in two ways. If feedback is near zero at the moment the ramp starts, the clock runs at one third of nominal until feedback rises. Once the ramp has finished, the same flag pulls the clock to its minimum rate as short-circuit protection. Disabling, supply undervoltage and over-temperature all stop switching and close the output discharge switch. An over-temperature shutdown holds until the recovered-temperature flag is seen, and the restart then goes through a fresh reference wake and soft-start. All delays are counted in ticks of an external timebase strobe.

Top module: `buck_start_seq`

## Requirements
- R1: In reset, and in the idle state, the outputs are ref_wake=0, sw_en=0, skip_force=0, dis_on=1, freq_div=00 and ramp_code=0.
- R2: The first clock with en_in=1 and no undervoltage sets ref_wake=1, with switching still off. Switching (sw_en=1, skip_force=1, ramp_code=0) begins on the clock that carries the WAKE_TICKS-th tick. Clocks without a tick do not advance the count.
- R3: During soft-start, ramp_code rises by exactly one on every clock with tick=1 and holds on clocks without a tick.
- R4: On the tick that brings ramp_code to all ones, skip_force falls and the block enters run with sw_en=1. ramp_code then stays at all ones.
- R5: Suppose fb_low=1 on the clock that starts soft-start. Then freq_div=01 (one third of nominal) until a clock during soft-start samples fb_low=0, after which freq_div=00 for the rest of the ramp.
- R6: In run, freq_div=10 (minimum rate) whenever fb_low=1 and 00 otherwise. During soft-start without the R5 condition, fb_low has no effect (freq_div=00).
- R7: en_in=0 during reference wake, soft-start or run returns the block to idle on the next clock, with the R1 outputs.
- R8: uvlo_in=1 returns every state, over-temperature included, to idle on the next clock. It also keeps the block idle while en_in is high.
- R9: ot_hot=1 during reference wake, soft-start or run stops switching and turns on discharge, with ref_wake=0. The block stays there until a clock with ot_cool=1 and ot_hot=0. That clock starts a new reference wake with ramp_code=0 if en_in=1, and otherwise goes to idle.
- R10: While in over-temperature shutdown, changes of en_in have no effect on the outputs.
- R11: sw_en and dis_on are never both 1, and freq_div never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_in | input | 1 | Regulator enable |
| uvlo_in | input | 1 | Supply undervoltage lockout flag |
| ot_hot | input | 1 | Over-temperature trip flag |
| ot_cool | input | 1 | Temperature recovered flag |
| fb_low | input | 1 | Feedback below short-circuit threshold |
| tick | input | 1 | Timebase strobe, one clock wide |
| ref_wake | output | 1 | Reference wake request |
| sw_en | output | 1 | Power stage switching enable |
| skip_force | output | 1 | Force pulse-skipping operation |
| freq_div | output | 2 | 00 nominal, 01 one third, 10 minimum |
| dis_on | output | 1 | Output discharge switch on |
| ramp_code | output | RAMP_W | Soft-start reference code |

## Verification
The bench builds the block with WAKE_TICKS=5 and RAMP_W=3, so a whole wake phase and a full ramp to code 7 take about a dozen clocks. This makes every state transition reachable in short vector sequences. The small values also put the exact tick that ends the wake phase and the saturation of the ramp at its top code within direct cycle-by-cycle comparison. Gaps in the tick stream and feedback changes part-way through the ramp can likewise be placed precisely.

// File: rtl/buck_start_seq.sv
module buck_start_seq #(
  parameter int WAKE_TICKS = 600,
  parameter int RAMP_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_in,
  input  logic              uvlo_in,
  input  logic              ot_hot,
  input  logic              ot_cool,
  input  logic              fb_low,
  input  logic              tick,
  output logic              ref_wake,
  output logic              sw_en,
  output logic              skip_force,
  output logic [1:0]        freq_div,
  output logic              dis_on,
  output logic [RAMP_W-1:0] ramp_code
);
  localparam int WAKE_W = $clog2(WAKE_TICKS + 1);
  localparam logic [WAKE_W-1:0] WAKE_LAST = WAKE_W'(WAKE_TICKS - 1);
  localparam logic [RAMP_W-1:0] RAMP_FULL = '1;

  typedef enum logic [2:0] {S_OFF, S_WAKE, S_SOFT, S_RUN, S_THERM} st_t;

  st_t st, st_nx;
  logic [WAKE_W-1:0] wcnt;
  logic [RAMP_W-1:0] ramp;
  logic div3;

  wire active    = (st == S_WAKE) || (st == S_SOFT) || (st == S_RUN);
  wire wake_done = (st == S_WAKE) && tick && (wcnt == WAKE_LAST);
  wire ramp_done = (st == S_SOFT) && tick && (ramp == RAMP_FULL - 1'b1);

  always_comb begin
    st_nx = st;
    if (uvlo_in) st_nx = S_OFF;
    else begin
      case (st)
        S_OFF:   if (en_in) st_nx = S_WAKE;
        S_WAKE, S_SOFT, S_RUN: begin
          if (!en_in)         st_nx = S_OFF;
          else if (ot_hot)    st_nx = S_THERM;
          else if (wake_done) st_nx = S_SOFT;
          else if (ramp_done) st_nx = S_RUN;
        end
        S_THERM: if (ot_cool && !ot_hot) st_nx = en_in ? S_WAKE : S_OFF;
        default: st_nx = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_OFF;
      wcnt <= '0;
      ramp <= '0;
      div3 <= 1'b0;
    end else begin
      st <= st_nx;

      if (st_nx != S_WAKE)              wcnt <= '0;
      else if (st == S_WAKE && tick)    wcnt <= wcnt + 1'b1;

      if (st_nx == S_SOFT) begin
        if (st == S_SOFT && tick && ramp != RAMP_FULL) ramp <= ramp + 1'b1;
      end else if (st_nx == S_RUN)      ramp <= RAMP_FULL;
      else                              ramp <= '0;

      if (st == S_WAKE && st_nx == S_SOFT) div3 <= fb_low;
      else if (st_nx != S_SOFT || !fb_low) div3 <= 1'b0;
    end
  end

  assign ref_wake   = active;
  assign sw_en      = (st == S_SOFT) || (st == S_RUN);
  assign skip_force = (st == S_SOFT);
  assign dis_on     = (st == S_OFF) || (st == S_THERM);
  assign ramp_code  = ramp;
  assign freq_div   = (st == S_SOFT && div3)  ? 2'b01 :
                      (st == S_RUN && fb_low) ? 2'b10 : 2'b00;
endmodule

module buck_start_seq_chk #(
  parameter int RAMP_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_in,
  input logic              uvlo_in,
  input logic              ot_hot,
  input logic              ref_wake,
  input logic              sw_en,
  input logic              skip_force,
  input logic [1:0]        freq_div,
  input logic              dis_on,
  input logic [RAMP_W-1:0] ramp_code
);
  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_en && dis_on));

  assert_fdiv_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    freq_div != 2'b11);

  assert_wake_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> ref_wake);

  assert_ramp_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && $past(sw_en)) |->
      (ramp_code == $past(ramp_code) || ramp_code == RAMP_W'($past(ramp_code) + 1'b1)));

  assert_skip_below_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    skip_force |-> (ramp_code != '1));

  assert_disable_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_in && sw_en) |=> (!sw_en && dis_on));

  assert_uvlo_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_in |=> (!sw_en && !ref_wake && dis_on && ramp_code == '0));

  assert_hot_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_hot && sw_en) |=> (!sw_en && dis_on));
endmodule

bind buck_start_seq buck_start_seq_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_in(en_in), .uvlo_in(uvlo_in), .ot_hot(ot_hot),
  .ref_wake(ref_wake), .sw_en(sw_en), .skip_force(skip_force),
  .freq_div(freq_div), .dis_on(dis_on), .ramp_code(ramp_code)
);

// File: tb/buck_start_seq_tb.sv
module buck_start_seq_tb;
  localparam int WT = 5;
  localparam int RW = 3;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_in = 1'b0, uvlo_in = 1'b0, ot_hot = 1'b0, ot_cool = 1'b0, fb_low = 1'b0, tick = 1'b0;
  logic ref_wake, sw_en, skip_force, dis_on;
  logic [1:0] freq_div;
  logic [RW-1:0] ramp_code;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  buck_start_seq #(.WAKE_TICKS(WT), .RAMP_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .uvlo_in(uvlo_in), .ot_hot(ot_hot),
    .ot_cool(ot_cool), .fb_low(fb_low), .tick(tick), .ref_wake(ref_wake),
    .sw_en(sw_en), .skip_force(skip_force), .freq_div(freq_div),
    .dis_on(dis_on), .ramp_code(ramp_code)
  );

  // inputs {en,uvlo,hot,cool,fb,tick} | expected {wake,sw,skip,dis,fdiv,ramp}
  localparam logic [14:0] VEC [NV] = '{
    15'b000001_0001_00_000,
    15'b110001_0001_00_000,
    15'b100000_1000_00_000,
    15'b100000_1000_00_000,
    15'b100001_1000_00_000,
    15'b100001_1000_00_000,
    15'b100001_1000_00_000,
    15'b100001_1000_00_000,
    15'b100011_1110_01_000,
    15'b100011_1110_01_001,
    15'b100010_1110_01_001,
    15'b100001_1110_00_010,
    15'b100011_1110_00_011,
    15'b100001_1110_00_100,
    15'b100001_1110_00_101,
    15'b100001_1110_00_110,
    15'b100001_1100_00_111,
    15'b100001_1100_00_111,
    15'b100011_1100_10_111,
    15'b000001_0001_00_000
  };

  function automatic string row_tag(int i);
    case (i)
      0:  return "R1";
      1:  return "R8";
      8, 11: return "R5";
      9, 10, 13, 14, 15: return "R3";
      16, 17: return "R4";
      12, 18: return "R6";
      19: return "R7";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [8:0] obs();
    return {ref_wake, sw_en, skip_force, dis_on, freq_div, ramp_code};
  endfunction

  task automatic chk(string tag, logic [8:0] exp);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, obs(), exp);
    end
  endtask

  task automatic step(logic [5:0] in);
    {en_in, uvlo_in, ot_hot, ot_cool, fb_low, tick} = in;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bring_up();
    for (int k = 0; k < 1 + WT + 7; k++) step(6'b100001);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 9'b0001_00_000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 9'b0001_00_000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14:9]);
      chk(row_tag(i), VEC[i][8:0]);
    end

    // R9 R10: thermal shutdown and recovery through a fresh start
    bring_up();
    chk("R4 run reached", 9'b1100_00_111);
    step(6'b101001);
    chk("R9 hot shutdown", 9'b0001_00_000);
    step(6'b001001);
    chk("R10 en low in thermal", 9'b0001_00_000);
    step(6'b100001);
    chk("R10 en high in thermal", 9'b0001_00_000);
    step(6'b101101);
    chk("R9 cool while still hot", 9'b0001_00_000);
    step(6'b100101);
    chk("R9 restart wake", 9'b1000_00_000);
    for (int k = 0; k < WT; k++) step(6'b100001);
    chk("R9 fresh soft-start", 9'b1110_00_000);

    // R8: undervoltage from run, then restart
    bring_up();
    step(6'b110001);
    chk("R8 uvlo in run", 9'b0001_00_000);
    step(6'b100001);
    chk("R8 restart after uvlo", 9'b1000_00_000);

    // R8: undervoltage in thermal goes idle, en then restarts
    step(6'b101001);
    chk("R9 hot in wake", 9'b0001_00_000);
    step(6'b111001);
    chk("R8 uvlo in thermal", 9'b0001_00_000);
    step(6'b100001);
    chk("R8 idle after thermal uvlo", 9'b1000_00_000);

    // R9: cooled with enable low goes idle
    step(6'b101001);
    step(6'b000101);
    chk("R9 cool with en low", 9'b0001_00_000);
    step(6'b100001);
    chk("R9 idle then enable", 9'b1000_00_000);

    // R7: disable during wake and soft-start
    step(6'b000001);
    chk("R7 disable in wake", 9'b0001_00_000);
    for (int k = 0; k < 1 + WT + 2; k++) step(6'b100001);
    chk("R3 two ramp ticks", 9'b1110_00_010);
    step(6'b000001);
    chk("R7 disable in soft-start", 9'b0001_00_000);

    // R1: reset from run
    bring_up();
    rst_n = 1'b0;
    #1;
    chk("R1 reset from run", 9'b0001_00_000);
    @(negedge clk);
    rst_n = 1'b1;
    step(6'b000000);
    chk("R1 idle after reset", 9'b0001_00_000);

    finish_run();
  end
endmodule